// File: doc/BRIEF.md
# GPIO Set/Clear Configuration Bank

This block is the register bank for one general-purpose I/O port of up to 32 lines. A processor reaches it over a plain 32-bit register bus with an address, a write strobe, write data, a read strobe and read data. Every per-line control field has one address that sets bits and a second address that clears bits. A driver can therefore change one line with a single write carrying a one-hot mask and never needs a read-modify-write sequence. The controlled fields are output level, direction, interrupt enable, interrupt mask, edge/level trigger select, polarity, debounce and dual-edge trigger.

The bank drives the pad output and output-enable vectors and the per-line configuration vectors that an interrupt detector beside it uses. It also drives one bit that unmasks the combined interrupt. Pad input levels pass through a two-flop synchronizer and are returned on a read. Only the direction field, the dual-edge field, the pin levels and the combined-interrupt mask can be read back. Every other address reads as zero.

Top module: `gpio_setclr_bank`

## Requirements
- R1: A write to a field's set address sets each line bit whose write-data bit is 1. Lines written with 0 keep their value.
- R2: A write to a field's clear address (set address + 0x4) clears each line bit whose write-data bit is 1. Other lines are unchanged.
- R3: The set addresses are 0x000 for output level (pad_out), 0x010 for direction, 0x020 for interrupt enable (cfg_irq_en), 0x030 for interrupt mask (cfg_irq_mask), 0x040 for edge select (cfg_edge), 0x050 for polarity (cfg_pol), 0x060 for debounce (cfg_dbnc) and 0x0B0 for dual-edge (cfg_dual).
- R4: pad_oe equals the direction field, where 1 means the line drives. A read of 0x018 returns the direction field.
- R5: A read of 0x0B8 returns the dual-edge field.
- R6: A read of 0x080 returns pad_in after a two-flop synchronizer. A change of pad_in is visible to a read issued two clock cycles after the change, and a read issued in the first cycle after the change still returns the old level.
- R7: Bit 0 of the register at 0x0A0 drives comb_unmask. Writing 1 to that bit sets comb_unmask to 1 and writing 0 sets it to 0. A read of 0x0A0 returns that bit in bit 0 and zero in bits 31:1.
- R8: bus_rdata carries the read result in the clock cycle after the one in which bus_rd is high. It is zero in any cycle that follows a cycle without bus_rd.
- R9: A read of any set or clear address, or of any address not listed in R4 to R7, returns zero.
- R10: After reset every field, comb_unmask, the synchronizer and bus_rdata are zero, so every line is an input and every interrupt is disabled.
- R11: A write changes only the field it addresses. Writes to read-only or unmapped addresses change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Output level per line |
| pad_oe | output | 32 | Output enable per line |
| cfg_irq_en | output | 32 | Interrupt enable per line |
| cfg_irq_mask | output | 32 | Interrupt mask per line |
| cfg_edge | output | 32 | Edge (1) or level (0) trigger per line |
| cfg_pol | output | 32 | Trigger polarity per line |
| cfg_dbnc | output | 32 | Debounce enable per line |
| cfg_dual | output | 32 | Dual-edge trigger per line |
| comb_unmask | output | 1 | Combined interrupt unmask |

## Verification
Every field register drives an output vector directly. A wrong bit left by a set, a clear or a wrongly decoded address therefore appears on the field's configuration port in the cycle after the write, and the bench compares all eight vectors after every write. Faults in the readback path for direction, dual-edge, pins and the combined mask show one cycle after the read strobe. A synchronizer that is one stage short or one stage long shows only in the exact cycle where a read follows a pad change, so that cycle is probed directly.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

  // Per-line fields, each held in its own set/clear register
  typedef enum logic [2:0] {
    FLD_OUT  = 3'd0,
    FLD_DIR  = 3'd1,
    FLD_IEN  = 3'd2,
    FLD_IMSK = 3'd3,
    FLD_EDGE = 3'd4,
    FLD_POL  = 3'd5,
    FLD_DBNC = 3'd6,
    FLD_DUAL = 3'd7
  } fld_e;

  localparam int NUM_FIELDS = 8;
  localparam int MAP_W      = 12;

  // Clear address sits one word above the set address
  localparam logic [MAP_W-1:0] CLR_STEP   = 12'h004;
  localparam logic [MAP_W-1:0] OFF_DIR_ST = 12'h018;
  localparam logic [MAP_W-1:0] OFF_PINS   = 12'h080;
  localparam logic [MAP_W-1:0] OFF_COMB   = 12'h0A0;
  localparam logic [MAP_W-1:0] OFF_DUAL_ST = 12'h0B8;

  function automatic logic [MAP_W-1:0] set_off(input int f);
    logic [MAP_W-1:0] r;
    case (f)
      0:       r = 12'h000;
      1:       r = 12'h010;
      2:       r = 12'h020;
      3:       r = 12'h030;
      4:       r = 12'h040;
      5:       r = 12'h050;
      6:       r = 12'h060;
      7:       r = 12'h0B0;
      default: r = 12'hFFC;
    endcase
    return r;
  endfunction

  function automatic logic [MAP_W-1:0] clr_off(input int f);
    return set_off(f) + CLR_STEP;
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= stg_d;
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] meta_q, sync_q;
  logic [W-1:0] meta_d, sync_d;

  always_comb begin
    meta_d = raw;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign synced = sync_q;
endmodule

// File: rtl/gpio_sc_field.sv
module gpio_sc_field #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = set_en | clr_en;
    q_d  = q_r;
    if (set_en) q_d = q_d | bits;
    if (clr_en) q_d = q_d & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_sc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LINES-1:0] dir,
  input  logic [NUM_LINES-1:0] dual,
  input  logic [NUM_LINES-1:0] pins,
  input  logic                 comb,
  output logic [DATA_W-1:0]    data
);
  always_comb begin
    data = '0;
    if (addr == ADDR_W'(OFF_DIR_ST))       data = DATA_W'(dir);
    else if (addr == ADDR_W'(OFF_DUAL_ST)) data = DATA_W'(dual);
    else if (addr == ADDR_W'(OFF_PINS))    data = DATA_W'(pins);
    else if (addr == ADDR_W'(OFF_COMB))    data = DATA_W'(comb);
  end
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_sc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_rd,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic [NUM_LINES-1:0] cfg_irq_en,
  output logic [NUM_LINES-1:0] cfg_irq_mask,
  output logic [NUM_LINES-1:0] cfg_edge,
  output logic [NUM_LINES-1:0] cfg_pol,
  output logic [NUM_LINES-1:0] cfg_dbnc,
  output logic [NUM_LINES-1:0] cfg_dual,
  output logic                 comb_unmask
);
  logic                                   rst_sync_n;
  logic [NUM_FIELDS-1:0]                  set_hit, clr_hit;
  logic [NUM_FIELDS-1:0][NUM_LINES-1:0]   fld_q;
  logic [NUM_LINES-1:0]                   line_bits;
  logic [NUM_LINES-1:0]                   pins_s;
  logic                                   comb_q, comb_d, comb_en;
  logic [DATA_W-1:0]                      rd_val, rdata_q, rdata_d;

  gpio_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  gpio_pad_sync #(.W(NUM_LINES)) u_pads (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .raw    (pad_in),
    .synced (pins_s)
  );

  assign line_bits = bus_wdata[NUM_LINES-1:0];

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    assign set_hit[f] = bus_wr && (bus_addr == ADDR_W'(set_off(f)));
    assign clr_hit[f] = bus_wr && (bus_addr == ADDR_W'(clr_off(f)));

    gpio_sc_field #(.W(NUM_LINES)) u_fld (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_en (set_hit[f]),
      .clr_en (clr_hit[f]),
      .bits   (line_bits),
      .q      (fld_q[f])
    );
  end

  // Combined interrupt mask: plain single-bit register
  always_comb begin
    comb_en = bus_wr && (bus_addr == ADDR_W'(OFF_COMB));
    comb_d  = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  comb_q <= 1'b0;
    else if (comb_en) comb_q <= comb_d;
  end

  gpio_rd_mux #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_rd (
    .addr (bus_addr),
    .dir  (fld_q[int'(FLD_DIR)]),
    .dual (fld_q[int'(FLD_DUAL)]),
    .pins (pins_s),
    .comb (comb_q),
    .data (rd_val)
  );

  always_comb begin
    rdata_d = bus_rd ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata    = rdata_q;
  assign pad_out      = fld_q[int'(FLD_OUT)];
  assign pad_oe       = fld_q[int'(FLD_DIR)];
  assign cfg_irq_en   = fld_q[int'(FLD_IEN)];
  assign cfg_irq_mask = fld_q[int'(FLD_IMSK)];
  assign cfg_edge     = fld_q[int'(FLD_EDGE)];
  assign cfg_pol      = fld_q[int'(FLD_POL)];
  assign cfg_dbnc     = fld_q[int'(FLD_DBNC)];
  assign cfg_dual     = fld_q[int'(FLD_DUAL)];
  assign comb_unmask  = comb_q;
endmodule

// File: rtl/gpio_sc_checker.sv
module gpio_sc_checker #(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 sync_ok,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 bus_rd,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_LINES-1:0] pad_out,
  input logic [NUM_LINES-1:0] pad_oe,
  input logic                 comb_unmask
);
  logic [NUM_LINES-1:0] wm;
  assign wm = bus_wdata[NUM_LINES-1:0];

  // R1
  out_set_sticks_chk: assert property (@(posedge clk) disable iff (!sync_ok)
    (bus_wr && bus_addr == ADDR_W'(12'h000)) |=> ((pad_out & $past(wm)) == $past(wm)));

  // R1
  out_zero_hold_chk: assert property (@(posedge clk) disable iff (!sync_ok)
    (bus_wr && bus_addr == ADDR_W'(12'h000)) |=>
      ((pad_out & ~$past(wm)) == ($past(pad_out) & ~$past(wm))));

  // R2
  out_clear_chk: assert property (@(posedge clk) disable iff (!sync_ok)
    (bus_wr && bus_addr == ADDR_W'(12'h004)) |=> ((pad_out & $past(wm)) == '0));

  // R4
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!sync_ok)
    !(bus_wr && (bus_addr == ADDR_W'(12'h010) || bus_addr == ADDR_W'(12'h014)))
      |=> $stable(pad_oe));

  // R7
  comb_follow_chk: assert property (@(posedge clk) disable iff (!sync_ok)
    (bus_wr && bus_addr == ADDR_W'(12'h0A0)) |=> (comb_unmask == $past(bus_wdata[0])));

  // R8
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!sync_ok)
    !bus_rd |=> (bus_rdata == '0));

  // R9
  rd_setaddr_zero_chk: assert property (@(posedge clk) disable iff (!sync_ok)
    (bus_rd && bus_addr == ADDR_W'(12'h000)) |=> (bus_rdata == '0));
endmodule

bind gpio_setclr_bank gpio_sc_checker #(
  .NUM_LINES (NUM_LINES),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk         (clk),
  .sync_ok     (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .comb_unmask (comb_unmask)
);

// File: tb/gpio_setclr_bank_bench.sv
module gpio_setclr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata, pad_in;
  logic [31:0] pad_out, pad_oe, cfg_irq_en, cfg_irq_mask, cfg_edge, cfg_pol, cfg_dbnc, cfg_dual;
  logic        comb_unmask;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_fld [8];
  logic        m_comb;
  logic [31:0] m_pins;

  always #10 clk = ~clk;

  gpio_setclr_bank u_gpio_setclr_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .cfg_irq_en(cfg_irq_en), .cfg_irq_mask(cfg_irq_mask), .cfg_edge(cfg_edge),
    .cfg_pol(cfg_pol), .cfg_dbnc(cfg_dbnc), .cfg_dual(cfg_dual),
    .comb_unmask(comb_unmask)
  );

  function automatic logic [11:0] b_set(input int f);
    case (f)
      0: return 12'h000; 1: return 12'h010; 2: return 12'h020; 3: return 12'h030;
      4: return 12'h040; 5: return 12'h050; 6: return 12'h060; default: return 12'h0B0;
    endcase
  endfunction

  function automatic logic [31:0] b_read(input logic [11:0] a);
    if (a == 12'h018) return m_fld[1];
    if (a == 12'h0B8) return m_fld[7];
    if (a == 12'h080) return m_pins;
    if (a == 12'h0A0) return {31'd0, m_comb};
    return 32'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk(pad_out == m_fld[0], {tag, " pad_out"}, pad_out, m_fld[0]);
    chk(pad_oe == m_fld[1], {tag, " pad_oe R4"}, pad_oe, m_fld[1]);
    chk(cfg_irq_en == m_fld[2], {tag, " irq_en"}, cfg_irq_en, m_fld[2]);
    chk(cfg_irq_mask == m_fld[3], {tag, " irq_mask"}, cfg_irq_mask, m_fld[3]);
    chk(cfg_edge == m_fld[4], {tag, " edge"}, cfg_edge, m_fld[4]);
    chk(cfg_pol == m_fld[5], {tag, " pol"}, cfg_pol, m_fld[5]);
    chk(cfg_dbnc == m_fld[6], {tag, " dbnc"}, cfg_dbnc, m_fld[6]);
    chk(cfg_dual == m_fld[7], {tag, " dual"}, cfg_dual, m_fld[7]);
    chk(comb_unmask == m_comb, {tag, " comb R7"}, {31'd0, comb_unmask}, {31'd0, m_comb});
  endtask

  // Write, update model, check every output one cycle later
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int f = 0; f < 8; f++) begin
      if (a == b_set(f))         m_fld[f] = m_fld[f] | d;
      if (a == b_set(f) + 12'h4) m_fld[f] = m_fld[f] & ~d;
    end
    if (a == 12'h0A0) m_comb = d[0];
    chk_outs(tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; pad_in = '0;
    for (int f = 0; f < 8; f++) m_fld[f] = '0;
    m_comb = 1'b0; m_pins = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk_outs("R10 reset");
    chk(bus_rdata == 32'd0, "R10 rdata", bus_rdata, 32'd0);
    rd(12'h080, 32'd0, "R10 pins");

    // R1 R3 set and zero-hold
    wr(12'h000, 32'hA5A5_0F0F, "R1 out set");
    wr(12'h000, 32'h0000_00F0, "R1 zero bits hold");
    // R2 clear
    wr(12'h004, 32'h0000_000F, "R2 out clear");
    // R4 direction and status
    wr(12'h010, 32'hFFFF_FFFF, "R4 dir set all");
    wr(12'h014, 32'h0001_0000, "R2 dir clear one");
    rd(12'h018, m_fld[1], "R4 dir status");
    // R5 dual edge
    wr(12'h0B0, 32'h8000_0001, "R5 dual set");
    wr(12'h0B4, 32'h0000_0001, "R5 dual clear");
    rd(12'h0B8, m_fld[7], "R5 dual status");
    // R3 remaining fields each touched once
    for (int f = 2; f < 7; f++) wr(b_set(f), 32'h1 << (f * 3), "R3 field map");
    // R7 combined mask
    wr(12'h0A0, 32'h0000_0001, "R7 unmask");
    rd(12'h0A0, 32'h1, "R7 readback");
    wr(12'h0A0, 32'hFFFF_FFFE, "R7 mask");
    rd(12'h0A0, 32'h0, "R7 readback zero");
    // R9 set/clear and unmapped reads
    rd(12'h000, 32'd0, "R9 set addr read");
    rd(12'h014, 32'd0, "R9 clr addr read");
    rd(12'h7FC, 32'd0, "R9 unmapped read");
    // R11 writes to read-only/unmapped leave outputs alone
    wr(12'h018, 32'hFFFF_FFFF, "R11 status write");
    wr(12'h080, 32'hFFFF_FFFF, "R11 pins write");
    wr(12'h300, 32'hFFFF_FFFF, "R11 unmapped write");
    // R8 idle rdata returns to zero
    @(negedge clk);
    chk(bus_rdata == 32'd0, "R8 idle zero", bus_rdata, 32'd0);
    // R6 synchronizer latency
    @(negedge clk);
    pad_in = 32'hC3C3_5A5A;
    rd(12'h080, m_pins, "R6 early read old");
    @(negedge clk);
    m_pins = pad_in;
    rd(12'h080, m_pins, "R6 synced read");

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      int f;
      logic [31:0] d;
      logic [11:0] a;
      op = int'($urandom_range(0, 9));
      f  = int'($urandom_range(0, 7));
      d  = ($urandom_range(0, 1) == 1) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      if (op <= 2)      wr(b_set(f), d, "R1 rnd set");
      else if (op <= 4) wr(b_set(f) + 12'h4, d, "R2 rnd clear");
      else if (op == 5) wr(12'h0A0, d, "R7 rnd comb");
      else if (op == 6) begin
        a = 12'($urandom) & 12'hFFC;
        wr(a, d, "R11 rnd any write");
      end else if (op == 7) begin
        @(negedge clk);
        pad_in = $urandom;
        repeat (2) @(negedge clk);
        m_pins = pad_in;
        rd(12'h080, m_pins, "R6 rnd pins");
      end else begin
        case ($urandom_range(0, 5))
          0: a = 12'h018;
          1: a = 12'h0B8;
          2: a = 12'h0A0;
          3: a = 12'h080;
          4: a = b_set(f) + 12'(4 * $urandom_range(0, 1));
          default: a = 12'($urandom) & 12'hFFC;
        endcase
        rd(a, b_read(a), "R9 rnd read");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule